// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the left/right frame clock for one audio port, together with a single-cycle frame-start strobe for the serializer that shifts the samples. In master mode it divides its own input master clock. The number of master clock cycles per frame and the number of bit clocks per frame are each chosen by a small encoded field. The bit clock divider is the quotient of the two. In slave mode the externally supplied bit and frame clocks are passed through, and the frame-start strobe is taken from a synchronised copy of the incoming frame clock.

Two configuration words drive it. The mode word holds the two ratio fields and the master-select bits. The inversion word holds four polarity bits: one per clock in each of the two roles. A generator enable starts the divided clocks once the ratio fields are in place. Dropping it lets the current bit finish before both clocks park at their idle level. Which master-select bit applies (output or input direction) is fixed per instance by a parameter.

Top module: `abclk_clock_gen`

## Requirements
- R1: Mode bits 14:12 give master clock cycles per frame M: code 0..4 selects 512, 256, 128, 64, 32 (M = 512 >> code); codes 5..7 are unused.
- R2: Mode bits 10:8 give bit clocks per frame B: code 0..4 selects 32 << code, code 7 selects 16; codes 5 and 6 are unused.
- R3: While master mode is selected, `cfg_err_o` is high exactly when a ratio code is unused or M/B is below 2. While the flag is high an enabled generator does not start and all outputs stay idle. In slave mode the flag is low.
- R4: With PORT_DIR = 0 mode bit 0 selects master mode; with PORT_DIR = 1 mode bit 4 does. The other bit has no effect. When the selected bit is clear the port is a slave.
- R5: In master mode, counting k master cycles from the edge that starts the generator (k = 0), the uninverted bit clock is high when (k mod D) >= D/2 with D = M/B. The uninverted frame clock is high when (k mod M) >= M/2, so it is low (left phase) for the first half of each frame.
- R6: In master mode `frame_start_o` is high for exactly the cycles where k mod M = 0, including the first cycle after start.
- R7: The generator starts on the first rising edge that sees the enable high with master mode and a valid setting. The ratio fields are captured at that edge, and later changes to them have no effect until the generator has stopped.
- R8: After the enable is seen low, the generator keeps running to the end of the current bit (the cycle with k mod D = D-1). From the next cycle the uninverted clocks and the strobe are 0. This idle state is also the reset state.
- R9: Inversion word: bit 12 inverts the frame clock and bit 8 the bit clock in master mode (idle level included); bit 4 inverts the frame clock and bit 0 the bit clock in slave mode. Bits of the other role have no effect.
- R10: In slave mode `frame_start_o` pulses for one cycle when the slave frame clock (after inversion) falls. Seen from the clock edge that first samples the new level, the pulse is high during the cycle that follows the SYNC_STAGES-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; also clocks all state |
| rst_n | input | 1 | Active-low reset |
| mode_reg | input | REG_W | Mode word: ratio fields and master-select bits |
| inv_reg | input | REG_W | Inversion word: four polarity bits |
| clk_en | input | 1 | Generator enable |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock out |
| lrclk_o | output | 1 | Frame clock out |
| frame_start_o | output | 1 | One-cycle frame-start strobe |
| cfg_err_o | output | 1 | Invalid ratio setting while master |

## Verification
The bench builds the block with its default parameters: 3-bit ratio fields, a 512-cycle longest frame, two synchroniser stages and PORT_DIR = 0. With these defaults all 64 combinations of the two ratio codes can be swept. Each valid pair is run for more than two full frames against an arithmetic waveform model, then stopped in the middle of a bit. Because the two-stage synchroniser and the 16-bit inversion word are small, every combination of the external clock levels and the slave inversion bits can be driven directly. The exact cycle of the slave frame-start pulse can then be predicted.

// File: rtl/abclk_pkg.sv
`timescale 1ns/1ps
package abclk_pkg;
   // width of every log2 quantity carried between the decoder and the sequencer
   localparam int LOG_W = 4;

   // field positions inside the mode word
   localparam int MCLK_FIELD_LSB = 12;
   localparam int BITS_FIELD_LSB = 8;
   localparam int OUT_MASTER_BIT = 0;
   localparam int IN_MASTER_BIT  = 4;

   // bit positions inside the inversion word
   localparam int INV_LR_MST_BIT   = 12;
   localparam int INV_BCLK_MST_BIT = 8;
   localparam int INV_LR_SLV_BIT   = 4;
   localparam int INV_BCLK_SLV_BIT = 0;

   // decoded ratio: log2 of master cycles per bit and log2 of bits per frame
   typedef struct packed {
      logic [LOG_W-1:0] div_log2;
      logic [LOG_W-1:0] bits_log2;
   } abclk_ratio_t;
endpackage

// File: rtl/abclk_ratio_decode.sv
`timescale 1ns/1ps
module abclk_ratio_decode
   import abclk_pkg::*;
#(
   parameter int FIELD_W        = 3,
   parameter int MCLK_TOP_LOG2  = 9,
   parameter int BITS_BASE_LOG2 = 5,
   parameter int BITS_ALT_LOG2  = 4,
   parameter int NUM_CODES      = 5,
   parameter int ALT_CODE       = 7
) (
   input  logic [FIELD_W-1:0] mclk_code_i,
   input  logic [FIELD_W-1:0] bits_code_i,
   output abclk_ratio_t       ratio_o,
   output logic               valid_o
);
   localparam int CODE_SPACE = 1 << FIELD_W;

   if (NUM_CODES >= CODE_SPACE) begin : g_chk_codes
      $error("abclk_ratio_decode: NUM_CODES must leave room in the code space");
   end
   if (ALT_CODE < NUM_CODES || ALT_CODE >= CODE_SPACE) begin : g_chk_alt
      $error("abclk_ratio_decode: ALT_CODE must be an otherwise unused code");
   end
   if (MCLK_TOP_LOG2 >= (1 << LOG_W) || BITS_BASE_LOG2 + NUM_CODES - 1 >= (1 << LOG_W)) begin : g_chk_log
      $error("abclk_ratio_decode: log2 values exceed LOG_W");
   end
   if (MCLK_TOP_LOG2 < NUM_CODES - 1) begin : g_chk_top
      $error("abclk_ratio_decode: MCLK_TOP_LOG2 too small for NUM_CODES");
   end

   logic [LOG_W-1:0] mclk_log2;
   logic [LOG_W-1:0] bits_log2;
   logic             mclk_ok;
   logic             bits_ok;
   logic             bits_alt;

   always_comb begin
      bits_alt  = (bits_code_i == FIELD_W'(ALT_CODE));
      mclk_ok   = (mclk_code_i < FIELD_W'(NUM_CODES));
      bits_ok   = (bits_code_i < FIELD_W'(NUM_CODES)) || bits_alt;
      mclk_log2 = LOG_W'(MCLK_TOP_LOG2) - LOG_W'(mclk_code_i);
      bits_log2 = bits_alt ? LOG_W'(BITS_ALT_LOG2)
                           : LOG_W'(BITS_BASE_LOG2) + LOG_W'(bits_code_i);
      // a generated bit needs at least one master cycle in each half
      valid_o   = mclk_ok && bits_ok && (mclk_log2 > bits_log2);
      ratio_o.div_log2  = mclk_log2 - bits_log2;
      ratio_o.bits_log2 = bits_log2;
   end
endmodule

// File: rtl/abclk_master_seq.sv
`timescale 1ns/1ps
module abclk_master_seq
   import abclk_pkg::*;
#(
   parameter int CYC_W = 5,
   parameter int BIT_W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_ok_i,
   input  logic         keep_i,
   input  abclk_ratio_t ratio_i,
   output logic         bclk_raw_o,
   output logic         lr_raw_o,
   output logic         fs_o,
   output logic         running_o
);
   if (CYC_W < 1 || BIT_W < 1) begin : g_chk_w
      $error("abclk_master_seq: counter widths must be positive");
   end

   logic             run_q;
   logic [CYC_W-1:0] cyc_q;
   logic [BIT_W-1:0] bit_q;
   abclk_ratio_t     ratio_q;

   logic [CYC_W-1:0] cyc_term;
   logic [CYC_W-1:0] cyc_half;
   logic [BIT_W-1:0] bit_term;
   logic [BIT_W-1:0] bit_half;
   logic             bit_end;

   // terminal counts are low-order masks; their top set bit marks the half point
   assign cyc_term = ~({CYC_W{1'b1}} << ratio_q.div_log2);
   assign cyc_half = cyc_term ^ (cyc_term >> 1);
   assign bit_term = ~({BIT_W{1'b1}} << ratio_q.bits_log2);
   assign bit_half = bit_term ^ (bit_term >> 1);
   assign bit_end  = (cyc_q == cyc_term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cyc_q   <= '0;
         bit_q   <= '0;
         ratio_q <= '0;
      end else if (!run_q) begin
         if (start_ok_i) begin
            run_q   <= 1'b1;
            ratio_q <= ratio_i;
         end
         cyc_q <= '0;
         bit_q <= '0;
      end else if (bit_end) begin
         cyc_q <= '0;
         if (!keep_i) begin
            run_q <= 1'b0;
            bit_q <= '0;
         end else if (bit_q == bit_term) begin
            bit_q <= '0;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   assign bclk_raw_o = run_q & |(cyc_q & cyc_half);
   assign lr_raw_o   = run_q & |(bit_q & bit_half);
   assign fs_o       = run_q & (cyc_q == '0) & (bit_q == '0);
   assign running_o  = run_q;

   // R8: the generator only leaves the running state at the last cycle of a bit
   assert_stop_at_bit_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(cyc_q) == $past(cyc_term)))
      else $error("generator stopped in the middle of a bit");

   // R5: the frame clock only changes where a new bit begins
   assert_lr_on_bit_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && (lr_raw_o != $past(lr_raw_o))) |-> (cyc_q == '0))
      else $error("frame clock changed inside a bit");

   // R6: the first running cycle is a frame start
   assert_start_is_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> fs_o)
      else $error("start did not open a frame");

   // R7: captured ratio stays fixed while running
   assert_ratio_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q)) |-> $stable(ratio_q))
      else $error("ratio changed while running");
endmodule

// File: rtl/abclk_slave_edge.sv
`timescale 1ns/1ps
module abclk_slave_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lr_i,
   output logic fs_o
);
   if (SYNC_STAGES < 1) begin : g_chk_stages
      $error("abclk_slave_edge: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= lr_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], lr_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   // falling edge of the synchronised frame clock marks the left phase
   assign fs_o = last_q & ~sync_q[SYNC_STAGES-1];

   // R10: the slave strobe lasts one cycle
   assert_slave_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fs_o |=> !fs_o)
      else $error("slave frame-start longer than one cycle");
endmodule

// File: rtl/abclk_clock_gen.sv
`timescale 1ns/1ps
module abclk_clock_gen
   import abclk_pkg::*;
#(
   parameter int REG_W          = 16,
   parameter int FIELD_W        = 3,
   parameter int MCLK_TOP_LOG2  = 9,
   parameter int BITS_BASE_LOG2 = 5,
   parameter int BITS_ALT_LOG2  = 4,
   parameter int NUM_CODES      = 5,
   parameter int ALT_CODE       = 7,
   parameter int SYNC_STAGES    = 2,
   parameter int PORT_DIR       = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] mode_reg,
   input  logic [REG_W-1:0] inv_reg,
   input  logic             clk_en,
   input  logic             ext_bclk,
   input  logic             ext_lrclk,
   output logic             bclk_o,
   output logic             lrclk_o,
   output logic             frame_start_o,
   output logic             cfg_err_o
);
   localparam int BITS_TOP_LOG2 = BITS_BASE_LOG2 + NUM_CODES - 1;
   localparam int BITS_MAX_LOG2 = (BITS_TOP_LOG2 > BITS_ALT_LOG2) ? BITS_TOP_LOG2 : BITS_ALT_LOG2;
   localparam int BITS_MIN_LOG2 = (BITS_ALT_LOG2 < BITS_BASE_LOG2) ? BITS_ALT_LOG2 : BITS_BASE_LOG2;
   localparam int CYC_W         = (MCLK_TOP_LOG2 > BITS_MIN_LOG2) ? MCLK_TOP_LOG2 - BITS_MIN_LOG2 : 1;
   localparam int BIT_W         = BITS_MAX_LOG2;

   if (REG_W < MCLK_FIELD_LSB + FIELD_W || FIELD_W > MCLK_FIELD_LSB - BITS_FIELD_LSB) begin : g_chk_reg
      $error("abclk_clock_gen: mode word too narrow for the ratio fields");
   end
   if (REG_W <= INV_LR_MST_BIT) begin : g_chk_inv
      $error("abclk_clock_gen: inversion word too narrow");
   end
   if (PORT_DIR != 0 && PORT_DIR != 1) begin : g_chk_dir
      $error("abclk_clock_gen: PORT_DIR must be 0 or 1");
   end

   abclk_ratio_t ratio;
   logic         ratio_ok;
   logic         is_master;
   logic         gen_bclk;
   logic         gen_lr;
   logic         gen_fs;
   logic         gen_running;
   logic         slv_lr;
   logic         slv_fs;
   logic         unused_cfg;

   assign unused_cfg = ^{mode_reg, inv_reg};

   if (PORT_DIR == 0) begin : g_dir_out
      assign is_master = mode_reg[OUT_MASTER_BIT];
   end else begin : g_dir_in
      assign is_master = mode_reg[IN_MASTER_BIT];
   end

   abclk_ratio_decode #(
      .FIELD_W        (FIELD_W),
      .MCLK_TOP_LOG2  (MCLK_TOP_LOG2),
      .BITS_BASE_LOG2 (BITS_BASE_LOG2),
      .BITS_ALT_LOG2  (BITS_ALT_LOG2),
      .NUM_CODES      (NUM_CODES),
      .ALT_CODE       (ALT_CODE)
   ) i_decode (
      .mclk_code_i (mode_reg[MCLK_FIELD_LSB +: FIELD_W]),
      .bits_code_i (mode_reg[BITS_FIELD_LSB +: FIELD_W]),
      .ratio_o     (ratio),
      .valid_o     (ratio_ok)
   );

   abclk_master_seq #(
      .CYC_W (CYC_W),
      .BIT_W (BIT_W)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok_i (clk_en & is_master & ratio_ok),
      .keep_i     (clk_en & is_master),
      .ratio_i    (ratio),
      .bclk_raw_o (gen_bclk),
      .lr_raw_o   (gen_lr),
      .fs_o       (gen_fs),
      .running_o  (gen_running)
   );

   assign slv_lr = ext_lrclk ^ inv_reg[INV_LR_SLV_BIT];

   abclk_slave_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_slave (
      .clk   (clk),
      .rst_n (rst_n),
      .lr_i  (slv_lr),
      .fs_o  (slv_fs)
   );

   always_comb begin
      if (is_master) begin
         bclk_o        = gen_bclk ^ inv_reg[INV_BCLK_MST_BIT];
         lrclk_o       = gen_lr   ^ inv_reg[INV_LR_MST_BIT];
         frame_start_o = gen_fs;
      end else begin
         bclk_o        = ext_bclk ^ inv_reg[INV_BCLK_SLV_BIT];
         lrclk_o       = slv_lr;
         frame_start_o = slv_fs;
      end
   end

   assign cfg_err_o = is_master & ~ratio_ok;

   // R3: an idle generator stays idle while the setting is flagged invalid
   assert_err_blocks_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_err_o) && !$past(gen_running)) |-> !gen_running)
      else $error("generator started with an invalid ratio");
endmodule

// File: tb/test_abclk_clock_gen.sv
`timescale 1ns/1ps
module test_abclk_clock_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mode_reg = '0;
   logic [15:0] inv_reg = '0;
   logic        clk_en = 1'b0;
   logic        ext_bclk = 1'b0;
   logic        ext_lrclk = 1'b0;
   logic        bclk_o, lrclk_o, frame_start_o, cfg_err_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   abclk_clock_gen i_abclk_clock_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_reg      (mode_reg),
      .inv_reg       (inv_reg),
      .clk_en        (clk_en),
      .ext_bclk      (ext_bclk),
      .ext_lrclk     (ext_lrclk),
      .bclk_o        (bclk_o),
      .lrclk_o       (lrclk_o),
      .frame_start_o (frame_start_o),
      .cfg_err_o     (cfg_err_o)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   function automatic logic [15:0] mk_mode(input int a, input int b, input bit m0, input bit m4);
      return (16'(a) << 12) | (16'(b) << 8) | (16'(m4) << 4) | 16'(m0);
   endfunction

   // run the generator, compare every cycle with the arithmetic model, stop at kstop
   task automatic run_master(input int d, input int m, input int kstop, input bit ib, input bit il,
                             input int chg_k, input logic [15:0] chg_mode, input string tag);
      int end_k;
      int e_clk = 0;
      int e_fs = 0;
      int e_stop = 0;
      bit eb, el, ef;
      end_k = kstop;
      while ((end_k % d) != d - 1) end_k++;
      clk_en = 1'b1;
      for (int k = 0; k <= end_k + 4; k++) begin
         @(negedge clk);
         if (k <= end_k) begin
            eb = ((k % d) >= d / 2) ^ ib;
            el = ((k % m) >= m / 2) ^ il;
            ef = ((k % m) == 0);
            if (bclk_o !== eb || lrclk_o !== el) e_clk++;
            if (frame_start_o !== ef) e_fs++;
         end else if (bclk_o !== ib || lrclk_o !== il || frame_start_o !== 1'b0) begin
            e_stop++;
         end
         if (k == kstop) clk_en = 1'b0;
         if (k == chg_k) mode_reg = chg_mode;
      end
      chk(e_clk == 0, {tag, " R5"}, $sformatf("clock mismatch cycles D=%0d M=%0d", d, m), e_clk, 0);
      chk(e_fs == 0, {tag, " R6"}, $sformatf("frame-start mismatch cycles D=%0d M=%0d", d, m), e_fs, 0);
      chk(e_stop == 0, {tag, " R8"}, $sformatf("not idle after stop D=%0d M=%0d", d, m), e_stop, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      finish_run();
   end

   initial begin
      int mlog, blog, bad;
      bit ok;
      // reset state (R8)
      mode_reg = mk_mode(0, 0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bclk_o == 0 && lrclk_o == 0 && frame_start_o == 0, "R8", "reset idle outputs",
          {bclk_o, lrclk_o, frame_start_o}, 0);
      chk(cfg_err_o == 0, "R3", "no error for valid default", cfg_err_o, 0);

      // sweep of all ratio code pairs (R1 R2 R3)
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            mlog = 9 - a;
            blog = (b == 7) ? 4 : 5 + b;
            ok = (a < 5) && (b < 5 || b == 7) && (mlog > blog);
            mode_reg = mk_mode(a, b, 1'b1, 1'b0);
            @(negedge clk);
            chk(cfg_err_o == !ok, "R1 R2 R3", $sformatf("cfg_err_o codes %0d/%0d", a, b), cfg_err_o, !ok);
            if (ok) begin
               run_master(1 << (mlog - blog), 1 << mlog, 2 * (1 << mlog) + (1 << (mlog - blog)) / 2,
                          1'b0, 1'b0, -1, '0, "R1 R2");
            end else begin
               bad = 0;
               clk_en = 1'b1;
               repeat (6) begin
                  @(negedge clk);
                  if (bclk_o || lrclk_o || frame_start_o) bad++;
               end
               clk_en = 1'b0;
               chk(bad == 0, "R3", $sformatf("outputs moved with invalid codes %0d/%0d", a, b), bad, 0);
            end
         end
      end

      // ratio change while running is ignored (R7): start with M=128 D=4, switch to M=512
      mode_reg = mk_mode(2, 0, 1'b1, 1'b0);
      @(negedge clk);
      run_master(4, 128, 300, 1'b0, 1'b0, 10, mk_mode(0, 0, 1'b1, 1'b0), "R7");

      // master inversion: all four bits set, only bits 12 and 8 matter (R9)
      mode_reg = mk_mode(3, 0, 1'b1, 1'b0);
      inv_reg  = 16'h1111;
      @(negedge clk);
      chk(bclk_o == 1 && lrclk_o == 1, "R9", "inverted idle levels", {bclk_o, lrclk_o}, 3);
      run_master(2, 64, 130, 1'b1, 1'b1, -1, '0, "R9");
      inv_reg = 16'h0011;
      @(negedge clk);
      chk(bclk_o == 0 && lrclk_o == 0, "R9", "slave bits ignored in master", {bclk_o, lrclk_o}, 0);

      // bit 4 does not select master with PORT_DIR=0; slave pass-through with inversion (R4 R9)
      mode_reg = mk_mode(0, 0, 1'b0, 1'b1);
      clk_en = 1'b1;
      bad = 0;
      for (int v = 0; v < 16; v++) begin
         ext_bclk  = v[0];
         ext_lrclk = v[1];
         inv_reg   = 16'h1100 | (16'(v[2]) << 0) | (16'(v[3]) << 4);
         #1;
         if (bclk_o !== (v[0] ^ v[2]) || lrclk_o !== (v[1] ^ v[3])) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R4 R9", "slave pass-through mismatches", bad, 0);
      mode_reg = mk_mode(7, 6, 1'b0, 1'b1);
      #1;
      chk(cfg_err_o == 0, "R3 R4", "no error flag in slave mode", cfg_err_o, 0);
      clk_en = 1'b0;

      // slave frame-start timing (R10)
      inv_reg = '0;
      ext_lrclk = 1'b1;
      repeat (5) @(negedge clk);
      ext_lrclk = 1'b0;
      @(negedge clk);
      chk(frame_start_o == 0, "R10", "strobe too early", frame_start_o, 0);
      @(negedge clk);
      chk(frame_start_o == 1, "R10", "strobe after second edge", frame_start_o, 1);
      @(negedge clk);
      chk(frame_start_o == 0, "R10", "strobe one cycle only", frame_start_o, 0);
      ext_lrclk = 1'b1;
      bad = 0;
      repeat (5) begin
         @(negedge clk);
         if (frame_start_o) bad++;
      end
      chk(bad == 0, "R10", "no strobe on rising frame clock", bad, 0);
      // with slave inversion the rising input is a falling left edge
      inv_reg = 16'h0010;
      @(negedge clk);
      chk(frame_start_o == 0, "R10 R9", "inverted strobe too early", frame_start_o, 0);
      @(negedge clk);
      chk(frame_start_o == 1, "R10 R9", "inverted strobe", frame_start_o, 1);

      finish_run();
   end
endmodule